// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block sits between a processor's load/store port and main memory. It holds one 32-bit word per line in a direct-mapped array. Each line carries a tag and a valid flag. A read that finds its word returns it in the same cycle. A read that does not find it stalls the processor while the word is fetched, then returns the word and installs it in the line.

Stores follow a write-through, write-allocate policy with no tag check. Every store overwrites the indexed line with the new tag and data, marks the line valid, and queues the word in a small write buffer. The buffer drains to memory one word at a time. A read miss first searches that buffer, so a word still waiting to be written is never read stale from memory.

The processor holds its request steady until `ready_o` is high. The low two address bits are ignored.

Top module: `dm_wt_cache`

## Requirements
- R1: After reset every line is invalid: `ready_o` and both memory request outputs are low with no request, and the first read of any address is a miss.
- R2: The line index is address bits [11:2] and the tag is bits [31:12]; bits [1:0] are ignored, so addresses differing only there reach the same word.
- R3: A read whose line is valid with an equal tag raises `ready_o` in the same cycle with the stored word on `rdata_o`, and issues no memory read.
- R4: Any other read that has no buffered match drops `ready_o`. From the next cycle `mem_rd_req_o` stays high with the word-aligned address (bits [1:0] zero) until `mem_rd_valid_i`. In that cycle `ready_o` is high and `rdata_o` equals `mem_rd_data_i`.
- R5: A read miss installs the fetched word with its tag. A later read of it hits, and the word that previously held that line now misses.
- R6: Every accepted write, whether or not it hits, overwrites the indexed line with its tag and data and sets it valid. A later read of that word hits with the written data.
- R7: Every accepted write appears on the memory write port exactly once, in acceptance order, with the word-aligned address. `mem_wr_req_o` is high exactly when at least one write is pending.
- R8: With four writes pending, a write request sees `ready_o` low until `mem_wr_ack_i` frees a slot.
- R9: A read missing in the array while the write buffer holds that word is answered in the same cycle with the youngest buffered value. It issues no memory read and installs that value in the line.
- R10: While `mem_wr_req_o` is high and not acknowledged, the write address and data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Processor access request, held until ready |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Store data |
| rdata_o | output | 32 | Load data, valid when ready_o is high on a load |
| ready_o | output | 1 | Access completes this cycle; low means stall |
| mem_rd_req_o | output | 1 | Memory word read request |
| mem_rd_addr_o | output | 32 | Word-aligned read address |
| mem_rd_valid_i | input | 1 | Read response valid |
| mem_rd_data_i | input | 32 | Read response data |
| mem_wr_req_o | output | 1 | Buffered write pending |
| mem_wr_addr_o | output | 32 | Word-aligned write address |
| mem_wr_data_o | output | 32 | Write data |
| mem_wr_ack_i | input | 1 | Memory accepts the pending write this cycle |

## Verification
The hardest case to reach is a read that misses in the array while its word is still waiting in the write buffer. The array always holds the newest store to a line, so that line must be evicted after the store but before the store drains. The stimulus holds `mem_wr_ack_i` low, stores twice to one word, then stores to a conflicting address with the same index. The read of the first word then misses in the array and must take the youngest buffered value. Holding acknowledgements off also fills the buffer, which drives the full-buffer stall. Acknowledgements are then re-enabled after a delay.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic {
    ST_IDLE,
    ST_MISS
  } ctrl_state_e;
endpackage

// File: rtl/cache_store.sv
module cache_store #(
  parameter int LINES  = 1024,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (wr_en_i) valid_q[idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[idx_i]  <= tag_i;
      data_q[idx_i] <= wr_data_i;
    end
  end

  assign hit_o     = valid_q[idx_i] && (tag_q[idx_i] == tag_i);
  assign rd_data_o = data_q[idx_i];
endmodule

// File: rtl/wr_buffer.sv
module wr_buffer #(
  parameter int DEPTH  = 4,
  parameter int WA_W   = 30,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [WA_W-1:0]   push_addr_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic [WA_W-1:0]   look_addr_i,
  output logic              full_o,
  output logic              head_valid_o,
  output logic [WA_W-1:0]   head_addr_o,
  output logic [DATA_W-1:0] head_data_o,
  output logic              fwd_hit_o,
  output logic [DATA_W-1:0] fwd_data_o
);
  logic [WA_W-1:0]   addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  rd_ptr_q, wr_ptr_q;
  logic [PTR_W:0]    count_q;

  assign full_o       = count_q == (PTR_W+1)'(DEPTH);
  assign head_valid_o = count_q != '0;
  assign head_addr_o  = addr_q[rd_ptr_q];
  assign head_data_o  = data_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[wr_ptr_q] <= push_addr_i;
      data_q[wr_ptr_q] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= rd_ptr_q + 1'b1;
      count_q <= count_q + (PTR_W+1)'(push_i) - (PTR_W+1)'(pop_i);
    end
  end

  // scan oldest to youngest; the youngest match wins
  always_comb begin
    fwd_hit_o  = 1'b0;
    fwd_data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [PTR_W-1:0] slot;
      slot = rd_ptr_q + PTR_W'(i);
      if ((PTR_W+1)'(i) < count_q && addr_q[slot] == look_addr_i) begin
        fwd_hit_o  = 1'b1;
        fwd_data_o = data_q[slot];
      end
    end
  end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] line_data_i,
  input  logic              fwd_hit_i,
  input  logic [DATA_W-1:0] fwd_data_i,
  input  logic              wb_full_i,
  input  logic              mem_rd_valid_i,
  input  logic [DATA_W-1:0] mem_rd_data_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              fill_en_o,
  output logic [DATA_W-1:0] fill_data_o,
  output logic              push_o,
  output logic              mem_rd_req_o
);
  ctrl_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d      = state_q;
    ready_o      = 1'b0;
    rdata_o      = line_data_i;
    fill_en_o    = 1'b0;
    fill_data_o  = wdata_i;
    push_o       = 1'b0;
    mem_rd_req_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i && we_i) begin
          // blind allocate: no tag check on stores
          ready_o   = !wb_full_i;
          fill_en_o = !wb_full_i;
          push_o    = !wb_full_i;
        end else if (req_i) begin
          if (hit_i) begin
            ready_o = 1'b1;
          end else if (fwd_hit_i) begin
            ready_o     = 1'b1;
            rdata_o     = fwd_data_i;
            fill_en_o   = 1'b1;
            fill_data_o = fwd_data_i;
          end else begin
            state_d = ST_MISS;
          end
        end
      end
      ST_MISS: begin
        mem_rd_req_o = 1'b1;
        if (mem_rd_valid_i) begin
          ready_o     = 1'b1;
          rdata_o     = mem_rd_data_i;
          fill_en_o   = 1'b1;
          fill_data_o = mem_rd_data_i;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int LINES    = 1024,
  parameter int WB_DEPTH = 4,
  localparam int OFF_W   = 2,
  localparam int IDX_W   = $clog2(LINES),
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W,
  localparam int WA_W    = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              mem_rd_req_o,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic              mem_rd_valid_i,
  input  logic [DATA_W-1:0] mem_rd_data_i,
  output logic              mem_wr_req_o,
  output logic [ADDR_W-1:0] mem_wr_addr_o,
  output logic [DATA_W-1:0] mem_wr_data_o,
  input  logic              mem_wr_ack_i
);
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [WA_W-1:0]   word;
  logic [OFF_W-1:0]  unused_off;
  logic              hit, fwd_hit, wb_full, fill_en, push;
  logic [DATA_W-1:0] line_data, fwd_data, fill_data;
  logic [WA_W-1:0]   head_addr;

  assign idx        = addr_i[OFF_W +: IDX_W];
  assign tag        = addr_i[ADDR_W-1 -: TAG_W];
  assign word       = addr_i[ADDR_W-1:OFF_W];
  assign unused_off = addr_i[OFF_W-1:0];

  assign mem_rd_addr_o = {word, {OFF_W{1'b0}}};
  assign mem_wr_addr_o = {head_addr, {OFF_W{1'b0}}};

  cache_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_store (
    .clk_i, .rst_ni,
    .idx_i(idx), .tag_i(tag),
    .wr_en_i(fill_en), .wr_data_i(fill_data),
    .hit_o(hit), .rd_data_o(line_data)
  );

  wr_buffer #(.DEPTH(WB_DEPTH), .WA_W(WA_W), .DATA_W(DATA_W)) i_wbuf (
    .clk_i, .rst_ni,
    .push_i(push), .push_addr_i(word), .push_data_i(wdata_i),
    .pop_i(mem_wr_req_o && mem_wr_ack_i),
    .look_addr_i(word),
    .full_o(wb_full),
    .head_valid_o(mem_wr_req_o), .head_addr_o(head_addr), .head_data_o(mem_wr_data_o),
    .fwd_hit_o(fwd_hit), .fwd_data_o(fwd_data)
  );

  cache_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk_i, .rst_ni,
    .req_i, .we_i, .wdata_i,
    .hit_i(hit), .line_data_i(line_data),
    .fwd_hit_i(fwd_hit), .fwd_data_i(fwd_data),
    .wb_full_i(wb_full),
    .mem_rd_valid_i, .mem_rd_data_i,
    .ready_o, .rdata_o,
    .fill_en_o(fill_en), .fill_data_o(fill_data),
    .push_o(push), .mem_rd_req_o
  );
endmodule

// File: rtl/cache_chk.sv
module cache_chk #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int WB_DEPTH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic              ready_o,
  input logic              mem_rd_req_o,
  input logic [ADDR_W-1:0] mem_rd_addr_o,
  input logic              mem_rd_valid_i,
  input logic              mem_wr_req_o,
  input logic [ADDR_W-1:0] mem_wr_addr_o,
  input logic [DATA_W-1:0] mem_wr_data_o,
  input logic              mem_wr_ack_i
);
  logic [7:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else pend_q <= pend_q + 8'(req_i && we_i && ready_o) - 8'(mem_wr_req_o && mem_wr_ack_i);
  end

  a_r7_pend_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q <= 8'(WB_DEPTH));

  a_r7_req_iff_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_req_o == (pend_q != '0));

  a_r8_full_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q == 8'(WB_DEPTH)) && req_i && we_i |-> !ready_o);

  a_r4_miss_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_req_o && !mem_rd_valid_i |=> mem_rd_req_o && $stable(mem_rd_addr_o));

  a_r4_stall_in_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_req_o && !mem_rd_valid_i |-> !ready_o);

  a_r4_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_req_o |-> mem_rd_addr_o[1:0] == 2'b00);

  a_r3_hit_no_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && ready_o && !mem_rd_valid_i |-> !mem_rd_req_o);

  a_r10_wr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_req_o && !mem_wr_ack_i |=> mem_wr_req_o && $stable(mem_wr_addr_o) && $stable(mem_wr_data_o));
endmodule

bind dm_wt_cache cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WB_DEPTH(WB_DEPTH)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .ready_o(ready_o),
  .mem_rd_req_o(mem_rd_req_o), .mem_rd_addr_o(mem_rd_addr_o), .mem_rd_valid_i(mem_rd_valid_i),
  .mem_wr_req_o(mem_wr_req_o), .mem_wr_addr_o(mem_wr_addr_o), .mem_wr_data_o(mem_wr_data_o),
  .mem_wr_ack_i(mem_wr_ack_i)
);

// File: tb/test_dm_wt_cache.sv
module test_dm_wt_cache;
  localparam int CLK_PERIOD = 10;
  localparam int WB = 4;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [31:0] rdata_o;
  logic        ready_o, mem_rd_req_o, mem_wr_req_o;
  logic [31:0] mem_rd_addr_o, mem_wr_addr_o, mem_wr_data_o;
  logic        mem_rd_valid = 1'b0, mem_wr_ack = 1'b0;
  logic [31:0] mem_rd_data = '0;

  int total = 0, bad = 0;
  bit ack_en = 1'b0;

  logic [19:0] m_tag   [int];
  logic [31:0] m_data  [int];
  logic [31:0] mem_m   [int];
  logic [29:0] q_addr  [$];
  logic [31:0] q_data  [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dm_wt_cache i_dm_wt_cache (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata_o), .ready_o(ready_o),
    .mem_rd_req_o(mem_rd_req_o), .mem_rd_addr_o(mem_rd_addr_o),
    .mem_rd_valid_i(mem_rd_valid), .mem_rd_data_i(mem_rd_data),
    .mem_wr_req_o(mem_wr_req_o), .mem_wr_addr_o(mem_wr_addr_o), .mem_wr_data_o(mem_wr_data_o),
    .mem_wr_ack_i(mem_wr_ack)
  );

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_val(input int w);
    if (mem_m.exists(w)) return mem_m[w];
    return {w[15:0] ^ 16'h5a3c, ~w[15:0]};
  endfunction

  // memory write port: compare with model queue each cycle, ack by policy
  always @(negedge clk) begin
    #2;
    if (rst_ni) begin
      chk(mem_wr_req_o == (q_addr.size() != 0), "R7 wr_req vs pending",
          32'(mem_wr_req_o), 32'(q_addr.size() != 0));
      if (mem_wr_req_o && q_addr.size() != 0) begin
        chk(mem_wr_addr_o == {q_addr[0], 2'b00}, "R7 wr addr order", mem_wr_addr_o, {q_addr[0], 2'b00});
        chk(mem_wr_data_o == q_data[0], "R7 wr data order", mem_wr_data_o, q_data[0]);
      end
      mem_wr_ack = ack_en && mem_wr_req_o;
    end
  end

  always @(posedge clk) begin
    if (rst_ni && mem_wr_req_o && mem_wr_ack && q_addr.size() != 0) begin
      mem_m[int'(q_addr[0])] = q_data[0];
      void'(q_addr.pop_front());
      void'(q_data.pop_front());
    end
  end

  task automatic do_read(input logic [31:0] a, input int lat, input string r);
    int idx, w;
    bit hit, fwd;
    logic [31:0] fd, mv;
    idx = int'(a[11:2]);
    w   = int'(a[31:2]);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1;
    hit = m_tag.exists(idx) && m_tag[idx] == a[31:12];
    fwd = 1'b0; fd = '0;
    foreach (q_addr[i]) if (q_addr[i] == a[31:2]) begin fwd = 1'b1; fd = q_data[i]; end
    if (hit) begin
      chk(ready_o == 1'b1, {r, " R3 hit ready"}, 32'(ready_o), 1);
      chk(rdata_o == m_data[idx], {r, " R3 hit data"}, rdata_o, m_data[idx]);
      chk(mem_rd_req_o == 1'b0, {r, " R3 no fetch"}, 32'(mem_rd_req_o), 0);
      @(posedge clk);
    end else if (fwd) begin
      chk(ready_o == 1'b1, {r, " R9 fwd ready"}, 32'(ready_o), 1);
      chk(rdata_o == fd, {r, " R9 fwd data"}, rdata_o, fd);
      @(posedge clk);
      m_tag[idx] = a[31:12]; m_data[idx] = fd;
      #1;
      chk(mem_rd_req_o == 1'b0, {r, " R9 no fetch"}, 32'(mem_rd_req_o), 0);
    end else begin
      chk(ready_o == 1'b0, {r, " R4 miss stall"}, 32'(ready_o), 0);
      @(posedge clk);
      repeat (lat) begin
        @(negedge clk); #1;
        chk(mem_rd_req_o == 1'b1, {r, " R4 rd req"}, 32'(mem_rd_req_o), 1);
        chk(mem_rd_addr_o == {a[31:2], 2'b00}, {r, " R4 rd addr"}, mem_rd_addr_o, {a[31:2], 2'b00});
        chk(ready_o == 1'b0, {r, " R4 wait stall"}, 32'(ready_o), 0);
        @(posedge clk);
      end
      @(negedge clk);
      mv = mem_val(w);
      mem_rd_valid = 1'b1; mem_rd_data = mv;
      #1;
      chk(ready_o == 1'b1, {r, " R4 resp ready"}, 32'(ready_o), 1);
      chk(rdata_o == mv, {r, " R4 resp data"}, rdata_o, mv);
      @(posedge clk);
      m_tag[idx] = a[31:12]; m_data[idx] = mv;
      #1 mem_rd_valid = 1'b0;
    end
    #1 req = 1'b0;
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d, input string r);
    bit exp_rdy;
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    forever begin
      #1;
      exp_rdy = q_addr.size() < WB;
      chk(ready_o == exp_rdy, {r, " R8 write ready"}, 32'(ready_o), 32'(exp_rdy));
      if (exp_rdy) break;
      @(posedge clk); @(negedge clk);
    end
    @(posedge clk);
    q_addr.push_back(a[31:2]); q_data.push_back(d);
    m_tag[int'(a[11:2])] = a[31:12]; m_data[int'(a[11:2])] = d;
    #1 req = 1'b0; we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1; #1;
    chk(ready_o == 1'b0, "R1 reset ready", 32'(ready_o), 0);
    chk(mem_rd_req_o == 1'b0, "R1 reset rd req", 32'(mem_rd_req_o), 0);
    chk(mem_wr_req_o == 1'b0, "R1 reset wr req", 32'(mem_wr_req_o), 0);
    ack_en = 1'b1;
    // R1 cold misses, R2 index/tag extremes
    do_read(32'h0000_0100, 3, "R1 cold");
    do_read(32'h0000_0100, 0, "R3");
    do_read(32'h0000_0103, 0, "R2 offset");
    do_read(32'h0000_0000, 0, "R2 idx0");
    do_read(32'hFFFF_FFFC, 2, "R2 idxmax");
    do_read(32'hFFFF_FFFD, 0, "R2 idxmax off");
    do_read(32'h0000_0FFC, 1, "R2 conflict top");
    // R5 conflict eviction
    do_read(32'h0000_1100, 2, "R5 evict");
    do_read(32'h0000_1100, 0, "R5 refill hit");
    do_read(32'h0000_0100, 1, "R5 old tag miss");
    // R6 write allocate on miss and hit
    do_write(32'h0000_2000, 32'hAAAA_0001, "R6 wr miss");
    do_read(32'h0000_2000, 0, "R6 read back");
    do_write(32'h0000_2002, 32'hAAAA_0002, "R6 wr hit");
    do_read(32'h0000_2000, 0, "R6 read hit");
    repeat (4) @(posedge clk);
    // R9 forwarding with drains held
    ack_en = 1'b0;
    @(negedge clk);
    do_write(32'h0000_3040, 32'h1111_0001, "R9 w1");
    do_write(32'h0000_3040, 32'h1111_0002, "R9 w2");
    do_write(32'h0000_7040, 32'h2222_0003, "R9 conflict");
    do_read(32'h0000_3040, 0, "R9 fwd youngest");
    do_read(32'h0000_3040, 0, "R9 filled hit");
    // R8 full buffer stall
    do_write(32'h0000_4000, 32'h3333_0004, "R8 fourth");
    fork begin repeat (5) @(posedge clk); ack_en = 1'b1; end join_none
    do_write(32'h0000_5000, 32'h4444_0005, "R8 fifth stalls");
    repeat (12) @(posedge clk);
    // R7 drained order: conflicting line forces a memory fetch of the last drained value
    do_write(32'h0000_B040, 32'h5555_0006, "R7 evict");
    repeat (4) @(posedge clk);
    do_read(32'h0000_3040, 2, "R7 mem has youngest");
    do_read(32'h0000_7040, 1, "R7 mem conflict word");
    @(negedge clk); #3;
    chk(mem_wr_req_o == 1'b0, "R7 drained", 32'(mem_wr_req_o), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule